// File: doc/BRIEF.md
# Peripheral clock generator with boot-time bypass default

The block derives one peripheral clock from four candidate sources: three PLL output clocks and the external reference clock, all arriving as inputs. For each PLL a bypass bit decides whether the generator uses that PLL's output or the reference clock in its place. After a full system reset, a boot strap pin decides the starting value of all three bypass bits together. Its level is taken on the first control-clock edge after reset is released. From then on, software may rewrite each bypass bit on its own.

The chosen source goes through three stages in turn. A glitch-free selector changes sources with a break-before-make handshake across each source's own clock domain. A divider with a 6-bit divide value follows it. Last comes a clock gate that software can turn off, and its enable is taken on a falling edge. Software reaches four small registers through a simple write strobe and a combinational read port, both clocked by the control clock.

Top module: `periclk_gen`

## Requirements
- R1: While `sysRstN` is low, `clkOut` stays low. After reset the PLL select register reads 0, the divide register reads 0 and the gate register reads 1.
- R2: On the first `sysClk` rising edge after `sysRstN` goes high, all three bypass bits take the level of `bootBypass`. A later change of `bootBypass` does not alter them.
- R3: A write to address 0 sets bypass bit i from `regWrData[i]` for PLL i (i = 0..2), each bit independently. A write issued in the same cycle as the strap capture is discarded and the strap value stays.
- R4: Address 1, bits [1:0], selects PLL 0, 1 or 2 as the generator's source. If that PLL's bypass bit is 1, the reference clock is used in its place. A write of value 3 is ignored and the old value is kept.
- R5: Address 2, bits [5:0], holds the divide value N. When N is 0 or 1, the source passes through undivided. Otherwise `clkOut` has a period of N source cycles and stays high for floor(N/2) of them.
- R6: Address 3, bit 0, is the gate enable. When it is 0, `clkOut` is held low. When it is set back to 1, the first output pulse is full width.
- R7: No more than one source is connected to the selector output at any time. While the source changes, no high pulse on `clkOut` is shorter than half the period of the faster of the two sources.
- R8: `regRdData` returns the register named by `regAddr`, zero-extended to 8 bits.
- R9: A register written on a `sysClk` edge holds the written value from the next cycle on. It keeps that value until it is written again or the system is reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sysClk | input | 1 | Control and register clock |
| sysRstN | input | 1 | Full system reset, active low, asynchronous assert |
| bootBypass | input | 1 | Boot strap: 1 starts all PLLs bypassed |
| refClk | input | 1 | External reference clock |
| pllClk | input | 3 | PLL output clocks, bit i is PLL i |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read data |
| clkOut | output | 1 | Generated peripheral clock |

## Verification
Two events can land on the same `sysClk` edge: the strap capture that follows reset release and a software write to the bypass register. The bench releases reset and raises a bypass write at the same instant. It then reads back the strap value and confirms that the output period belongs to the source the strap chose. The bench also sweeps the divide value and several source choices, and derives each expected high time and period from the source period. A pulse-width monitor runs through repeated bypass toggles and through gate re-enable.

// File: rtl/periclk_pkg.sv
`timescale 1ns/1ps
package periclk_pkg;
  parameter int NPLL  = 3;
  parameter int NSRC  = NPLL + 1;
  parameter int DIVW  = 6;
  parameter int DATAW = 8;
  parameter int ADDRW = 2;
  parameter int SELW  = $clog2(NPLL);
  parameter int SRCW  = $clog2(NSRC);

  parameter logic [ADDRW-1:0] ADDR_BYPASS = 2'd0;
  parameter logic [ADDRW-1:0] ADDR_SEL    = 2'd1;
  parameter logic [ADDRW-1:0] ADDR_DIV    = 2'd2;
  parameter logic [ADDRW-1:0] ADDR_GATE   = 2'd3;

  typedef struct packed {
    logic [NSRC-1:0] srcPick;  // one-hot source request, MSB = reference
    logic [DIVW-1:0] divVal;
    logic            gateOn;
  } ctrlBus_t;
endpackage

// File: rtl/periclk_ctrl.sv
`timescale 1ns/1ps
module periclk_ctrl
  import periclk_pkg::*;
(
  input  logic             sysClk,
  input  logic             sysRstN,
  input  logic             bootBypass,
  input  logic             regWrEn,
  input  logic [ADDRW-1:0] regAddr,
  input  logic [DATAW-1:0] regWrData,
  output logic [DATAW-1:0] regRdData,
  output logic [NPLL-1:0]  bypassQ,
  output logic             strapDone,
  output ctrlBus_t         ctrlBus
);
  logic [SELW-1:0] selQ;
  logic [DIVW-1:0] divQ;
  logic            gateQ;
  logic [SRCW-1:0] pickIdx;
  logic            unusedWr;

  assign unusedWr = ^regWrData[DATAW-1:DIVW];

  always_ff @(posedge sysClk or negedge sysRstN) begin
    if (!sysRstN) begin
      strapDone <= 1'b0;
      bypassQ   <= '0;
      selQ      <= '0;
      divQ      <= '0;
      gateQ     <= 1'b1;
    end else begin
      if (!strapDone) begin
        strapDone <= 1'b1;
        bypassQ   <= {NPLL{bootBypass}};
      end else if (regWrEn && regAddr == ADDR_BYPASS) begin
        bypassQ <= regWrData[NPLL-1:0];
      end
      if (regWrEn && regAddr == ADDR_SEL && regWrData[SELW-1:0] < SELW'(NPLL))
        selQ <= regWrData[SELW-1:0];
      if (regWrEn && regAddr == ADDR_DIV)
        divQ <= regWrData[DIVW-1:0];
      if (regWrEn && regAddr == ADDR_GATE)
        gateQ <= regWrData[0];
    end
  end

  always_comb begin
    pickIdx         = bypassQ[selQ] ? SRCW'(NPLL) : SRCW'(selQ);
    ctrlBus.srcPick = NSRC'(1) << pickIdx;
    ctrlBus.divVal  = divQ;
    ctrlBus.gateOn  = gateQ;
  end

  always_comb begin
    case (regAddr)
      ADDR_BYPASS: regRdData = DATAW'(bypassQ);
      ADDR_SEL:    regRdData = DATAW'(selQ);
      ADDR_DIV:    regRdData = DATAW'(divQ);
      default:     regRdData = DATAW'(gateQ);
    endcase
  end
endmodule

// File: rtl/periclk_selcell.sv
`timescale 1ns/1ps
module periclk_selcell (
  input  logic srcClk,
  input  logic rstN,
  input  logic want,
  input  logic othersIdle,
  output logic active,
  output logic leg
);
  logic [1:0] syncQ;

  // two-stage synchronizer in this source's domain
  always_ff @(posedge srcClk or negedge rstN) begin
    if (!rstN) syncQ <= '0;
    else       syncQ <= {syncQ[0], want & othersIdle};
  end

  // enable changes only while the source is low
  always_ff @(negedge srcClk or negedge rstN) begin
    if (!rstN) active <= 1'b0;
    else       active <= syncQ[1];
  end

  assign leg = srcClk & active;
endmodule

// File: rtl/periclk_datapath.sv
`timescale 1ns/1ps
module periclk_datapath
  import periclk_pkg::*;
(
  input  logic            refClk,
  input  logic [NPLL-1:0] pllClk,
  input  logic            rstN,
  input  ctrlBus_t        ctrlBus,
  output logic [NSRC-1:0] srcActive,
  output logic            clkOut
);
  logic [NSRC-1:0] srcClks;
  logic [NSRC-1:0] legs;
  logic            muxClk;

  assign srcClks = {refClk, pllClk};

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    localparam logic [NSRC-1:0] SELF = NSRC'(1) << i;
    periclk_selcell u_cell (
      .srcClk    (srcClks[i]),
      .rstN      (rstN),
      .want      (ctrlBus.srcPick[i]),
      .othersIdle(~|(srcActive & ~SELF)),
      .active    (srcActive[i]),
      .leg       (legs[i])
    );
  end

  assign muxClk = |legs;

  // divider
  logic [DIVW-1:0] cnt, cntNext, halfN;
  logic            passThru, divReg, divClk, gateLatch;

  assign passThru = ctrlBus.divVal <= DIVW'(1);
  assign halfN    = ctrlBus.divVal >> 1;
  assign cntNext  = (cnt >= ctrlBus.divVal - DIVW'(1)) ? '0 : cnt + DIVW'(1);

  always_ff @(posedge muxClk or negedge rstN) begin
    if (!rstN) begin
      cnt    <= '0;
      divReg <= 1'b0;
    end else begin
      cnt    <= cntNext;
      divReg <= cntNext < halfN;
    end
  end

  assign divClk = passThru ? muxClk : divReg;

  // gate enable taken while the clock is low
  always_ff @(negedge divClk or negedge rstN) begin
    if (!rstN) gateLatch <= 1'b0;
    else       gateLatch <= ctrlBus.gateOn;
  end

  assign clkOut = divClk & gateLatch;
endmodule

// File: rtl/periclk_gen.sv
`timescale 1ns/1ps
module periclk_gen
  import periclk_pkg::*;
(
  input  logic             sysClk,
  input  logic             sysRstN,
  input  logic             bootBypass,
  input  logic             refClk,
  input  logic [NPLL-1:0]  pllClk,
  input  logic             regWrEn,
  input  logic [ADDRW-1:0] regAddr,
  input  logic [DATAW-1:0] regWrData,
  output logic [DATAW-1:0] regRdData,
  output logic             clkOut
);
  ctrlBus_t        ctrlBus;
  logic [NPLL-1:0] bypassQ;
  logic            strapDone;
  logic [NSRC-1:0] srcActive;

  periclk_ctrl u_ctrl (
    .sysClk    (sysClk),
    .sysRstN   (sysRstN),
    .bootBypass(bootBypass),
    .regWrEn   (regWrEn),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .bypassQ   (bypassQ),
    .strapDone (strapDone),
    .ctrlBus   (ctrlBus)
  );

  periclk_datapath u_dp (
    .refClk   (refClk),
    .pllClk   (pllClk),
    .rstN     (sysRstN),
    .ctrlBus  (ctrlBus),
    .srcActive(srcActive),
    .clkOut   (clkOut)
  );
endmodule

// File: rtl/periclk_gen_chk.sv
`timescale 1ns/1ps
module periclk_gen_chk
  import periclk_pkg::*;
(
  input logic             sysClk,
  input logic             sysRstN,
  input logic             bootBypass,
  input logic             regWrEn,
  input logic [ADDRW-1:0] regAddr,
  input logic [DATAW-1:0] regWrData,
  input logic [NPLL-1:0]  bypassQ,
  input logic             strapDone,
  input logic [DIVW-1:0]  divVal,
  input logic [NSRC-1:0]  srcActive
);
  AST_STRAP_LOAD: assert property (@(posedge sysClk) disable iff (!sysRstN)
    $rose(strapDone) |-> bypassQ == {NPLL{$past(bootBypass)}}); // R2

  AST_BYPASS_WRITE: assert property (@(posedge sysClk) disable iff (!sysRstN)
    (strapDone && regWrEn && regAddr == ADDR_BYPASS) |=> bypassQ == $past(regWrData[NPLL-1:0])); // R3

  AST_DIV_WRITE: assert property (@(posedge sysClk) disable iff (!sysRstN)
    (regWrEn && regAddr == ADDR_DIV) |=> divVal == $past(regWrData[DIVW-1:0])); // R9

  AST_CFG_HOLD: assert property (@(posedge sysClk) disable iff (!sysRstN)
    (strapDone && !regWrEn) |=> ($stable(bypassQ) && $stable(divVal))); // R9

  AST_ONE_SOURCE: assert property (@(posedge sysClk) disable iff (!sysRstN)
    $onehot0(srcActive)); // R7
endmodule

bind periclk_gen periclk_gen_chk u_chk (
  .sysClk    (sysClk),
  .sysRstN   (sysRstN),
  .bootBypass(bootBypass),
  .regWrEn   (regWrEn),
  .regAddr   (regAddr),
  .regWrData (regWrData),
  .bypassQ   (bypassQ),
  .strapDone (strapDone),
  .divVal    (ctrlBus.divVal),
  .srcActive (srcActive)
);

// File: tb/tb_periclk_gen.sv
`timescale 1ns/1ps
module tb_periclk_gen;
  localparam int CLK_PERIOD = 10;
  localparam real P_PLL0 = 6.0;
  localparam real P_PLL1 = 8.0;
  localparam real P_PLL2 = 14.0;
  localparam real P_REF  = 26.0;

  logic       sysClk = 0, refClk = 0;
  logic [2:0] pllClk = '0;
  logic       sysRstN, bootBypass, regWrEn;
  logic [1:0] regAddr;
  logic [7:0] regWrData, regRdData;
  logic       clkOut;

  int  checks = 0, fails = 0, pulses = 0;
  bit  monOn = 0;
  real minHigh = 1.0e9, tRise = 0.0;

  always #(CLK_PERIOD/2.0) sysClk = ~sysClk;
  always #(P_REF/2.0)  refClk    = ~refClk;
  always #(P_PLL0/2.0) pllClk[0] = ~pllClk[0];
  always #(P_PLL1/2.0) pllClk[1] = ~pllClk[1];
  always #(P_PLL2/2.0) pllClk[2] = ~pllClk[2];

  periclk_gen dut (
    .sysClk(sysClk), .sysRstN(sysRstN), .bootBypass(bootBypass),
    .refClk(refClk), .pllClk(pllClk), .regWrEn(regWrEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .clkOut(clkOut)
  );

  always @(posedge clkOut) begin
    pulses++;
    tRise = $realtime;
  end
  always @(negedge clkOut) begin
    if (monOn && ($realtime - tRise) < minHigh) minHigh = $realtime - tRise;
  end

  function automatic void summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endfunction

  task automatic checkInt(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic checkReal(string req, string what, real act, real exp);
    checks++;
    if (act < exp - 0.01 || act > exp + 0.01) begin
      fails++;
      $display("FAIL %s %s: actual %0.2f expected %0.2f", req, what, act, exp);
    end
  endtask

  task automatic wrReg(logic [1:0] a, logic [7:0] d);
    @(negedge sysClk);
    regWrEn = 1; regAddr = a; regWrData = d;
    @(negedge sysClk);
    regWrEn = 0;
  endtask

  task automatic rdReg(logic [1:0] a, output int d);
    @(negedge sysClk);
    regAddr = a;
    #1 d = int'(regRdData);
  endtask

  task automatic measure(output real hi, output real per);
    real t0, t1, t2;
    repeat (3) @(posedge clkOut);
    t0 = $realtime; @(negedge clkOut);
    t1 = $realtime; @(posedge clkOut);
    t2 = $realtime;
    hi = t1 - t0; per = t2 - t0;
  endtask

  task automatic expectClk(string req, string what, real p, int n);
    real hi, per, eHi, ePer;
    repeat (60) @(negedge sysClk);
    measure(hi, per);
    ePer = (n <= 1) ? p : p * n;
    eHi  = (n <= 1) ? p / 2.0 : p * (n / 2);
    checkReal(req, {what, " high"}, hi, eHi);
    checkReal(req, {what, " period"}, per, ePer);
  endtask

  task automatic doReset(logic strapVal, bit collide);
    @(negedge sysClk);
    sysRstN = 0; regWrEn = 0;
    repeat (20) @(negedge sysClk);
    bootBypass = strapVal;
    if (collide) begin
      regWrEn = 1; regAddr = 2'd0; regWrData = 8'h05;
    end
    sysRstN = 1;
    @(negedge sysClk);
    regWrEn = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    int rd, p0;
    sysRstN = 0; bootBypass = 1; regWrEn = 0; regAddr = 0; regWrData = 0;
    repeat (30) @(negedge sysClk);
    checkInt("R1", "pulses during reset", pulses, 0);
    checkInt("R1", "clkOut during reset", int'(clkOut), 0);

    // strap = 1: all bypassed
    bootBypass = 1;
    @(negedge sysClk); sysRstN = 1;
    @(negedge sysClk);
    rdReg(2'd0, rd); checkInt("R2", "bypass after strap 1", rd, 7);
    rdReg(2'd1, rd); checkInt("R1", "select reset", rd, 0);
    rdReg(2'd2, rd); checkInt("R1", "divide reset", rd, 0);
    rdReg(2'd3, rd); checkInt("R8", "gate read zero-extended", rd, 1);
    bootBypass = 0;
    repeat (10) @(negedge sysClk);
    rdReg(2'd0, rd); checkInt("R2", "strap change after boot", rd, 7);
    expectClk("R4", "strap bypass uses reference", P_REF, 0);

    // strap = 0 with colliding write
    doReset(1'b0, 1'b1);
    rdReg(2'd0, rd); checkInt("R3", "write in capture cycle discarded", rd, 0);
    expectClk("R2", "strap 0 uses pll0", P_PLL0, 0);

    // independent bypass bits
    wrReg(2'd0, 8'h02);
    rdReg(2'd0, rd); checkInt("R3", "bypass write", rd, 2);
    expectClk("R3", "pll0 not bypassed", P_PLL0, 0);
    wrReg(2'd1, 8'h01);
    expectClk("R4", "pll1 bypassed to ref", P_REF, 0);
    wrReg(2'd1, 8'h02);
    expectClk("R4", "pll2 direct", P_PLL2, 0);
    wrReg(2'd0, 8'h05);
    expectClk("R3", "pll2 bypassed", P_REF, 0);
    wrReg(2'd1, 8'h01);
    expectClk("R3", "pll1 direct", P_PLL1, 0);
    wrReg(2'd1, 8'h03);
    rdReg(2'd1, rd); checkInt("R4", "select 3 ignored", rd, 1);

    // divider sweep on pll1
    for (int n = 0; n <= 12; n++) begin
      wrReg(2'd2, 8'(n));
      rdReg(2'd2, rd); checkInt("R9", "divide readback", rd, n);
      expectClk("R5", $sformatf("pll1 N=%0d", n), P_PLL1, n);
    end
    wrReg(2'd2, 8'd63);
    expectClk("R5", "pll1 N=63", P_PLL1, 63);
    // divider on reference
    wrReg(2'd0, 8'h07);
    for (int n = 2; n <= 5; n++) begin
      wrReg(2'd2, 8'(n));
      expectClk("R5", $sformatf("ref N=%0d", n), P_REF, n);
    end

    // glitch-free switching, undivided
    wrReg(2'd2, 8'd0);
    repeat (60) @(negedge sysClk);
    minHigh = 1.0e9; monOn = 1;
    for (int k = 0; k < 8; k++) begin
      wrReg(2'd0, (k % 2 == 0) ? 8'h05 : 8'h07);
      repeat (40) @(negedge sysClk);
    end
    monOn = 0;
    checkInt("R7", "min high pulse >= 4.0 during switching", int'(minHigh >= 3.99), 1);

    // gate
    wrReg(2'd0, 8'h05);
    wrReg(2'd3, 8'h00);
    repeat (20) @(negedge sysClk);
    p0 = pulses;
    repeat (200) @(negedge sysClk);
    checkInt("R6", "pulses while gated", pulses - p0, 0);
    checkInt("R6", "clkOut while gated", int'(clkOut), 0);
    minHigh = 1.0e9; monOn = 1;
    wrReg(2'd3, 8'h01);
    repeat (40) @(negedge sysClk);
    monOn = 0;
    checkInt("R6", "pulses resume", int'(pulses > p0), 1);
    checkReal("R6", "first pulses full width", minHigh, P_PLL1 / 2.0);

    summary();
    $finish;
  end
endmodule